// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Sensed Dead Time

This block turns one PWM command into two gate-enable outputs for a half bridge: `hi_on` for the upper switch and `lo_on` for the lower switch. The PWM level chooses which switch should conduct. The block always turns the conducting switch off first. It then waits for a sensed sign that this switch is really off, counts a short turn-on delay, and only then enables the other switch. The dead time therefore follows the real behaviour of the power stage instead of a fixed count.

The sense flags come from comparators outside the block and are already synchronous to `clk`. `lo_gate_low` says the lower gate has discharged. `hi_sw_off` says the upper switch has stopped conducting. If `hi_sw_off` never arrives, a timeout stands in for it, so the lower switch can still turn on. There is no such timeout on the upper side.

Three conditions force both outputs off regardless of PWM: the active-high enable `drive_en` going low, the undervoltage flag, and the overtemperature flag. When they clear, the sequencer restarts from an idle state. The PWM, enable and fault inputs each pass through a two-flop synchronizer. After the lower output drops, a minimum-off timer keeps it low for a set time. All delays are counted in clock cycles and set by parameters.

Top module: `halfbridge_deadtime_seq`

## Requirements
Counting rule: "edge k" is the k-th rising clock edge after an input changes between two edges. The numbers below use the default parameters ON_DELAY_CYC=2, OFF_TIMEOUT_CYC=17, LO_MIN_OFF_CYC=4.

- R1: While `rst_n` is low, and on the first cycle after it rises, both `hi_on` and `lo_on` are low.
- R2: `hi_on` and `lo_on` are never high in the same cycle.
- R3: PWM rise, with `lo_on` high and `lo_gate_low` already high: `lo_on` falls at edge 3 and `hi_on` rises at edge 4+ON_DELAY_CYC (edge 6).
- R4: PWM fall, with `hi_on` high and `hi_sw_off` already high: `hi_on` falls at edge 3 and `lo_on` rises at edge 4+ON_DELAY_CYC (edge 6).
- R5: If `hi_sw_off` stays low, a PWM fall still turns `lo_on` on. `hi_on` falls at edge 3 and `lo_on` rises at edge OFF_TIMEOUT_CYC+ON_DELAY_CYC+4 (edge 23).
- R6: While `lo_gate_low` stays low, `hi_on` never rises, whatever the PWM level.
- R7: If `drive_en` goes low, both outputs are low from edge 3 on, regardless of PWM.
- R8: If `uv_flag` goes high, both outputs are low from edge 3 on, and stay low while it is high.
- R9: If `ot_flag` goes high, both outputs are low from edge 3 on, and stay low while it is high.
- R10: Once `lo_on` falls, it stays low for at least LO_MIN_OFF_CYC+1 cycles. Example: a PWM high pulse one cycle long, with both sense flags high, makes `lo_on` fall at edge 3 and rise again at edge 8.
- R11: When the enable or the faults release, the sequencer starts again from idle and goes through the full handshake. With PWM high and `lo_gate_low` high, `hi_on` rises at edge 4+ON_DELAY_CYC (edge 6) after `drive_en` rises.
- R12: If PWM reverses while a turn-on is still waiting or delaying, that turn-on is dropped. In the R10 pulse example `hi_on` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_cmd | input | 1 | PWM command; high selects the upper switch (asynchronous) |
| drive_en | input | 1 | Drive enable; low forces both outputs off (asynchronous) |
| uv_flag | input | 1 | Undervoltage flag, high = fault (asynchronous) |
| ot_flag | input | 1 | Overtemperature flag, high = fault (asynchronous) |
| lo_gate_low | input | 1 | Lower gate discharged (synchronous) |
| hi_sw_off | input | 1 | Upper switch has stopped conducting (synchronous) |
| hi_on | output | 1 | Upper switch gate enable |
| lo_on | output | 1 | Lower switch gate enable |

## Verification
The assertions check every cycle that the two outputs never overlap and that a synchronized halt clears both outputs one cycle later. They also check that each output rises only after the opposite output was already low and while the synchronized PWM selected it, and that `lo_on` never comes back before its minimum-off run. The exact edges on which outputs change can only be shown by the bench's scenarios: the handshake delays, the timeout path, the restart after a disable, and the dropped turn-on after a short PWM pulse.

// File: rtl/hbdt_pkg.sv
// Shared types and helpers for the half-bridge dead-time sequencer.
// Assumes: all counts are positive cycle numbers.
package hbdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI_WAIT,
        ST_HI_DLY,
        ST_HI_ON,
        ST_LO_WAIT,
        ST_LO_DLY,
        ST_LO_ON
    } seq_state_t;

    // Counter width able to hold the largest of three counts.
    function automatic int cnt_bits(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/hbdt_sync.sv
// Two-flop synchronizer for a bundle of independent asynchronous bits.
// Assumes: each bit is a level; bits are not required to stay coherent with each other.
module hbdt_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/hbdt_timer.sv
// Load-and-count-down cycle timer. It stops at zero and reports zero.
// Assumes: load wins over counting; INIT is the value after reset.
module hbdt_timer #(
    parameter int          W    = 4,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Load, or count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= INIT;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/halfbridge_deadtime_seq.sv
// Half-bridge gate sequencer with sensed dead time.
// Turns one PWM level into exclusive upper/lower gate enables. A turn-on waits for
// a sense flag showing the opposite switch is off, then a fixed delay. A timeout
// stands in for the upper-off flag. A disable or a fault forces both outputs off
// and restarts the sequence from idle.
// Assumes: lo_gate_low and hi_sw_off are synchronous to clk; all parameters >= 1.
module halfbridge_deadtime_seq
    import hbdt_pkg::*;
#(
    parameter int ON_DELAY_CYC    = 2,
    parameter int OFF_TIMEOUT_CYC = 17,
    parameter int LO_MIN_OFF_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_cmd,
    input  logic drive_en,
    input  logic uv_flag,
    input  logic ot_flag,
    input  logic lo_gate_low,
    input  logic hi_sw_off,
    output logic hi_on,
    output logic lo_on
);

    localparam int CW = cnt_bits(ON_DELAY_CYC, OFF_TIMEOUT_CYC, LO_MIN_OFF_CYC);
    localparam logic [CW-1:0] DLY_LOAD = CW'(ON_DELAY_CYC - 1);
    localparam logic [CW-1:0] TMO_LOAD = CW'(OFF_TIMEOUT_CYC);
    localparam logic [CW-1:0] MO_LOAD  = CW'(LO_MIN_OFF_CYC);

    logic [3:0] sync_q;
    logic       pwm_s, en_s, uv_s, ot_s, halt;

    hbdt_sync #(.W(4), .RST_VAL(4'b0000)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ot_flag, uv_flag, drive_en, pwm_cmd}),
        .q_sync  (sync_q)
    );

    assign {ot_s, uv_s, en_s, pwm_s} = sync_q;
    assign halt = !en_s || uv_s || ot_s;

    seq_state_t st_q, st_n;
    logic       hi_q, lo_q, hi_n, lo_n;
    logic       dly_load, tmo_load, mo_load;
    logic       dly_zero, tmo_zero, mo_zero;

    hbdt_timer #(.W(CW), .INIT('0)) u_dly (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(DLY_LOAD), .zero(dly_zero)
    );

    hbdt_timer #(.W(CW), .INIT('0)) u_tmo (
        .clk(clk), .rst_n(rst_n), .load(tmo_load), .load_val(TMO_LOAD), .zero(tmo_zero)
    );

    hbdt_timer #(.W(CW), .INIT(MO_LOAD)) u_minoff (
        .clk(clk), .rst_n(rst_n), .load(mo_load), .load_val(MO_LOAD), .zero(mo_zero)
    );

    // Next state, next outputs and timer loads.
    always_comb begin
        st_n     = st_q;
        hi_n     = hi_q;
        lo_n     = lo_q;
        dly_load = 1'b0;
        tmo_load = 1'b0;
        if (halt) begin
            st_n = ST_IDLE;
            hi_n = 1'b0;
            lo_n = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (pwm_s) st_n = ST_HI_WAIT;
                    else begin st_n = ST_LO_WAIT; tmo_load = 1'b1; end
                end
                ST_HI_WAIT: begin
                    if (!pwm_s) begin st_n = ST_LO_WAIT; tmo_load = 1'b1; end
                    else if (lo_gate_low && !lo_q) begin st_n = ST_HI_DLY; dly_load = 1'b1; end
                end
                ST_HI_DLY: begin
                    if (!pwm_s) begin st_n = ST_LO_WAIT; tmo_load = 1'b1; end
                    else if (dly_zero) begin st_n = ST_HI_ON; hi_n = 1'b1; end
                end
                ST_HI_ON: begin
                    if (!pwm_s) begin st_n = ST_LO_WAIT; tmo_load = 1'b1; hi_n = 1'b0; end
                end
                ST_LO_WAIT: begin
                    if (pwm_s) st_n = ST_HI_WAIT;
                    else if (!hi_q && (hi_sw_off || tmo_zero)) begin
                        st_n = ST_LO_DLY; dly_load = 1'b1;
                    end
                end
                ST_LO_DLY: begin
                    if (pwm_s) st_n = ST_HI_WAIT;
                    else if (dly_zero && mo_zero) begin st_n = ST_LO_ON; lo_n = 1'b1; end
                end
                ST_LO_ON: begin
                    if (pwm_s) begin st_n = ST_HI_WAIT; lo_n = 1'b0; end
                end
                default: begin
                    st_n = ST_IDLE; hi_n = 1'b0; lo_n = 1'b0;
                end
            endcase
        end
    end

    // Start the minimum-off window whenever the lower enable drops.
    assign mo_load = lo_q && !lo_n;

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            st_q <= st_n;
            hi_q <= hi_n;
            lo_q <= lo_n;
        end
    end

    assign hi_on = hi_q;
    assign lo_on = lo_q;

    // Checker state: how long lo_on has been low, saturating at LO_MIN_OFF_CYC.
    logic [CW-1:0] lo_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                 lo_low_run <= '0;
        else if (lo_q)              lo_low_run <= '0;
        else if (lo_low_run < MO_LOAD) lo_low_run <= lo_low_run + 1'b1;
    end

    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_on && lo_on));

    // R7, R8 and R9 all act through halt.
    a_r7_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!hi_on && !lo_on));

    a_r3_hi_rise_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_on) |-> ($past(pwm_s) && !$past(lo_on)));

    a_r4_lo_rise_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_on) |-> (!$past(pwm_s) && !$past(hi_on)));

    a_r10_min_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_on) |-> (lo_low_run >= MO_LOAD));

endmodule

// File: tb/halfbridge_deadtime_seq_tb.sv
`timescale 1ns/1ps
module halfbridge_deadtime_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_cmd = 1'b0, drive_en = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
    logic lo_gate_low = 1'b0, hi_sw_off = 1'b0;
    logic hi_on, lo_on;

    int checks = 0;
    int failures = 0;
    int overlap = 0;

    always #2.5 clk = ~clk;

    halfbridge_deadtime_seq dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .drive_en(drive_en),
        .uv_flag(uv_flag), .ot_flag(ot_flag), .lo_gate_low(lo_gate_low),
        .hi_sw_off(hi_sw_off), .hi_on(hi_on), .lo_on(lo_on)
    );

    // Fields: {req[7:0], pwm, en, uv, ot, hs_off, lg_low, exp_hi, exp_lo}
    localparam logic [15:0] VECS [12] = '{
        {8'd4,  8'b0100_1101},   // R4 low side on
        {8'd3,  8'b1100_1110},   // R3 high side on
        {8'd7,  8'b1000_1100},   // R7 disabled
        {8'd11, 8'b1100_1110},   // R11 release
        {8'd8,  8'b1110_1100},   // R8 undervoltage
        {8'd4,  8'b0100_1101},   // R4 back to low side
        {8'd9,  8'b0101_1100},   // R9 overtemperature
        {8'd9,  8'b0100_1101},   // R9 release
        {8'd6,  8'b1100_1000},   // R6 no discharge seen
        {8'd5,  8'b0100_0001},   // R5 timeout path
        {8'd3,  8'b1100_0110},   // R3 high side on
        {8'd7,  8'b1011_0100}    // R7 all off
    };

    always @(negedge clk) if (hi_on && lo_on) overlap++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watch outputs for up to lim cycles; record first rise/fall cycle of each (-1: none).
    task automatic observe(input int lim, input bit pulse,
                           output int hr, output int hf, output int lr, output int lf);
        logic ph, pl;
        ph = hi_on; pl = lo_on;
        hr = -1; hf = -1; lr = -1; lf = -1;
        for (int n = 1; n <= lim; n++) begin
            @(negedge clk);
            if (pulse && n == 1) pwm_cmd = 1'b0;
            if (hi_on && !ph && hr < 0) hr = n;
            if (!hi_on && ph && hf < 0) hf = n;
            if (lo_on && !pl && lr < 0) lr = n;
            if (!lo_on && pl && lf < 0) lf = n;
            ph = hi_on; pl = lo_on;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int hr, hf, lr, lf;
        // R1 reset
        repeat (4) @(negedge clk);
        check(!hi_on && !lo_on, "R1 in reset", {hi_on, lo_on}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!hi_on && !lo_on, "R1 after reset", {hi_on, lo_on}, 0);

        // Vector table
        foreach (VECS[i]) begin
            @(negedge clk);
            {pwm_cmd, drive_en, uv_flag, ot_flag, hi_sw_off, lo_gate_low} = VECS[i][7:2];
            repeat (40) @(negedge clk);
            check({hi_on, lo_on} == VECS[i][1:0], $sformatf("R%0d vector %0d", VECS[i][15:8], i),
                  {hi_on, lo_on}, VECS[i][1:0]);
        end

        // Restore to high side on
        @(negedge clk);
        {pwm_cmd, drive_en, uv_flag, ot_flag, hi_sw_off, lo_gate_low} = 6'b110011;
        repeat (40) @(negedge clk);

        // R4 falling handshake
        pwm_cmd = 1'b0;
        observe(30, 1'b0, hr, hf, lr, lf);
        check(hf == 3, "R4 hi fall edge", hf, 3);
        check(lr == 6, "R4 lo rise edge", lr, 6);

        // R3 rising handshake
        @(negedge clk); pwm_cmd = 1'b1;
        observe(30, 1'b0, hr, hf, lr, lf);
        check(lf == 3, "R3 lo fall edge", lf, 3);
        check(hr == 6, "R3 hi rise edge", hr, 6);

        // R5 timeout without the off flag
        @(negedge clk); hi_sw_off = 1'b0; pwm_cmd = 1'b0;
        observe(40, 1'b0, hr, hf, lr, lf);
        check(hf == 3, "R5 hi fall edge", hf, 3);
        check(lr == 23, "R5 lo rise edge", lr, 23);

        // R10 / R12 one-cycle PWM pulse
        @(negedge clk); hi_sw_off = 1'b1;
        repeat (10) @(negedge clk);
        pwm_cmd = 1'b1;
        observe(30, 1'b1, hr, hf, lr, lf);
        check(lf == 3, "R10 lo fall edge", lf, 3);
        check(lr == 8, "R10 lo rise edge after min-off", lr, 8);
        check(hr == -1, "R12 dropped hi turn-on", hr, -1);

        // R7 disable, then R11 release with PWM high
        @(negedge clk); drive_en = 1'b0;
        observe(10, 1'b0, hr, hf, lr, lf);
        check(lf == 3, "R7 lo off edge", lf, 3);
        @(negedge clk); pwm_cmd = 1'b1;
        repeat (10) @(negedge clk);
        check(!hi_on && !lo_on, "R7 held off", {hi_on, lo_on}, 0);
        drive_en = 1'b1;
        observe(30, 1'b0, hr, hf, lr, lf);
        check(hr == 6, "R11 hi rise after release", hr, 6);
        check(lr == -1, "R11 lo stays off", lr, -1);

        // R8 and R9 fault entry latency
        @(negedge clk); uv_flag = 1'b1;
        observe(10, 1'b0, hr, hf, lr, lf);
        check(hf == 3, "R8 hi off edge", hf, 3);
        @(negedge clk); uv_flag = 1'b0;
        repeat (20) @(negedge clk);
        ot_flag = 1'b1;
        observe(10, 1'b0, hr, hf, lr, lf);
        check(hf == 3, "R9 hi off edge", hf, 3);

        check(overlap == 0, "R2 overlap cycles", overlap, 0);
        finish_run();
    end

endmodule